// File: doc/BRIEF.md
# Errored Second Monitor

This block is a performance monitor for a 2.048 Mbit/s framed line. Its one-second timer runs on the receive clock. When the timer reaches its terminal count, the block emits a single-cycle second-tick event, so downstream logic gets a steady once-per-second mark that follows the line rather than the local system clock.

Alongside the timer, the block watches eight defect inputs coming from the receive path. Each input may be a one-cycle event pulse or a level that stays high while an alarm persists. A defect input counts only while its bit in an 8-bit enable word is set.

If any enabled defect is seen during a one-second window, an errored-second event is raised together with that window's second tick. Both event pulses are meant to set bits in an interrupt status register elsewhere in the chip.

Top module: `errsec_monitor`

## Requirements
- R1: While `rx_rst_n` is low, both outputs are low. Releasing reset restarts the window and clears any accumulated defect, so the first window after reset begins with a clean record.
- R2: `sec_tick_o` is high for exactly one cycle in every `TICKS_PER_SEC` cycles. The first pulse is visible after the `TICKS_PER_SEC`-th rising edge following reset release. The default is 2,048,000 cycles for a 2.048 MHz receive clock.
- R3: `err_sec_o` is high only in a cycle in which `sec_tick_o` is also high.
- R4: `err_sec_o` goes high with a tick if and only if, in at least one cycle of the window that tick closes, some bit k had both `defect_i[k]` and `defect_en_i[k]` high.
- R5: A defect whose enable bit is low has no effect on `err_sec_o`, whatever its duration or position.
- R6: A level defect that stays high across several windows produces an errored second at the close of each of those windows.
- R7: A window runs from the cycle after the previous terminal cycle up to and including the cycle before the next terminal cycle, plus the previous terminal cycle itself. In other words, a defect present in the cycle in which the timer expires counts toward the following window and not the one closing.
- R8: The accumulated record is cleared at each window boundary, so one isolated defect produces exactly one errored second.
- R9: Bit positions are shared by `defect_i` and `defect_en_i`, as follows:
  - bit 0: frame alignment loss
  - bit 1: framing-word error
  - bit 2: CRC error
  - bit 3: alarm indication signal
  - bit 4: loss of signal
  - bit 5: line code violation
  - bit 6: receive slip in either direction
  - bit 7: E-bit error

  Any single enabled bit on its own is enough to flag the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive clock; all timing is counted in its cycles |
| rx_rst_n | input | 1 | Asynchronous active-low reset |
| defect_i | input | 8 | Defect pulses or levels, synchronous to `rx_clk`, bit map as in R9 |
| defect_en_i | input | 8 | Per-defect enable word, same bit map |
| sec_tick_o | output | 1 | One-cycle pulse at the end of each one-second window |
| err_sec_o | output | 1 | One-cycle pulse, coincident with the tick, when the window saw an enabled defect |

## Verification
The assertions take for granted that `defect_i` and `defect_en_i` are already synchronous to `rx_clk` and are stable around the rising edge. The assertions also assume `TICKS_PER_SEC` is at least two, so that a tick can be followed by a quiet cycle.

The bench meets these assumptions by changing every input on the falling edge only. It shortens the window to sixteen cycles so that pulses at the first, last and terminal positions of a window can all be placed directly. It also holds levels across boundaries and applies a reset in the middle of a window.

// File: rtl/errsec_pkg.sv
package errsec_pkg;

    // Number of defect sources watched by the monitor.
    localparam int NUM_DEFECTS = 8;

    // Bit positions shared by the defect and enable words.
    localparam int DEF_FRAME_LOSS  = 0;
    localparam int DEF_FRAMING_ERR = 1;
    localparam int DEF_CRC_ERR     = 2;
    localparam int DEF_ALARM_IND   = 3;
    localparam int DEF_SIGNAL_LOSS = 4;
    localparam int DEF_CODE_VIOL   = 5;
    localparam int DEF_SLIP        = 6;
    localparam int DEF_EBIT_ERR    = 7;

    // Registered event outputs of the top level.
    typedef struct packed {
        logic tick;
        logic err_sec;
    } event_regs_t;

    // Accumulator state: any enabled defect seen in the running window.
    typedef struct packed {
        logic seen;
    } accum_regs_t;

endpackage

// File: rtl/errsec_sec_timer.sv
module errsec_sec_timer #(
    parameter int unsigned TICKS_PER_SEC = 2048000
) (
    input  logic rx_clk,
    input  logic rx_rst_n,
    output logic expire_o
);
    localparam int                CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0]  TERM  = CNT_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t state_d;
    timer_regs_t state_q;

    logic at_term;

    // Terminal cycle: last position of the current window.
    assign at_term = (state_q.cnt == TERM);

    always_comb begin
        state_d = state_q;
        if (at_term) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign expire_o = at_term;

endmodule

// File: rtl/errsec_defect_gate.sv
module errsec_defect_gate #(
    parameter int N = errsec_pkg::NUM_DEFECTS
) (
    input  logic [N-1:0] defect_i,
    input  logic [N-1:0] defect_en_i,
    output logic         hit_o
);
    logic [N-1:0] gated;

    // One gate per source; a disabled source is forced quiet.
    for (genvar k = 0; k < N; k++) begin : g_src
        assign gated[k] = defect_i[k] & defect_en_i[k];
    end

    assign hit_o = |gated;

endmodule

// File: rtl/errsec_accum.sv
module errsec_accum (
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic hit_i,
    input  logic expire_i,
    output logic seen_o
);
    import errsec_pkg::*;

    accum_regs_t state_d;
    accum_regs_t state_q;

    always_comb begin
        state_d = state_q;
        if (expire_i) begin
            // Window closes: restart the record; this cycle's hit opens the next one.
            state_d.seen = hit_i;
        end else begin
            state_d.seen = state_q.seen | hit_i;
        end
    end

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Record of the window so far, excluding the current cycle.
    assign seen_o = state_q.seen;

endmodule

// File: rtl/errsec_monitor.sv
module errsec_monitor #(
    parameter int unsigned TICKS_PER_SEC = 2048000
) (
    input  logic       rx_clk,
    input  logic       rx_rst_n,
    input  logic [7:0] defect_i,
    input  logic [7:0] defect_en_i,
    output logic       sec_tick_o,
    output logic       err_sec_o
);
    import errsec_pkg::*;

    logic expire;
    logic hit;
    logic seen;

    event_regs_t out_d;
    event_regs_t out_q;

    errsec_sec_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) i_timer (
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .expire_o (expire)
    );

    errsec_defect_gate #(
        .N (NUM_DEFECTS)
    ) i_gate (
        .defect_i    (defect_i),
        .defect_en_i (defect_en_i),
        .hit_o       (hit)
    );

    errsec_accum i_accum (
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .hit_i    (hit),
        .expire_i (expire),
        .seen_o   (seen)
    );

    always_comb begin
        out_d         = '0;
        out_d.tick    = expire;
        out_d.err_sec = expire & seen;
    end

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sec_tick_o = out_q.tick;
    assign err_sec_o  = out_q.err_sec;

endmodule

// File: rtl/errsec_monitor_chk.sv
module errsec_monitor_chk #(
    parameter int unsigned TICKS_PER_SEC = 2048000
) (
    input logic       rx_clk,
    input logic       rx_rst_n,
    input logic [7:0] defect_i,
    input logic [7:0] defect_en_i,
    input logic       sec_tick_o,
    input logic       err_sec_o
);
    localparam int               GAP_W    = $clog2(TICKS_PER_SEC + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(TICKS_PER_SEC);

    logic [GAP_W-1:0] gap_q;
    logic             any_q;
    logic             last_hit_q;
    logic             hit_now;

    assign hit_now = |(defect_i & defect_en_i);

    // Edges since the last observed tick (or since reset).
    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            gap_q      <= '0;
            any_q      <= 1'b0;
            last_hit_q <= 1'b0;
        end else begin
            gap_q      <= sec_tick_o ? GAP_W'(1) : gap_q + GAP_W'(1);
            any_q      <= sec_tick_o ? (hit_now | last_hit_q) : (any_q | hit_now);
            last_hit_q <= hit_now;
        end
    end

    // R1: outputs quiet while reset is applied
    always @(posedge rx_clk) begin
        if (!rx_rst_n) begin
            a_r1_quiet_in_reset: assert (!sec_tick_o && !err_sec_o);
        end
    end

    a_r2_tick_period: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        sec_tick_o |-> (gap_q == GAP_FULL));

    a_r2_tick_not_late: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        gap_q <= GAP_FULL);

    a_r2_tick_single: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        sec_tick_o |=> !sec_tick_o);

    a_r3_es_with_tick: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        err_sec_o |-> sec_tick_o);

    a_r4_es_needs_defect: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        err_sec_o |-> any_q);

endmodule

bind errsec_monitor errsec_monitor_chk #(
    .TICKS_PER_SEC (TICKS_PER_SEC)
) i_errsec_monitor_chk (
    .rx_clk      (rx_clk),
    .rx_rst_n    (rx_rst_n),
    .defect_i    (defect_i),
    .defect_en_i (defect_en_i),
    .sec_tick_o  (sec_tick_o),
    .err_sec_o   (err_sec_o)
);

// File: tb/test_errsec_monitor.sv
`timescale 1ns/1ps
module test_errsec_monitor;
    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] defect = '0;
    logic [7:0] defect_en = '0;
    logic       tick;
    logic       es;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    errsec_monitor #(.TICKS_PER_SEC(T)) i_errsec_monitor (
        .rx_clk      (clk),
        .rx_rst_n    (rst_n),
        .defect_i    (defect),
        .defect_en_i (defect_en),
        .sec_tick_o  (tick),
        .err_sec_o   (es)
    );

    // Behavioural reference: position in window and "enabled defect seen" flag.
    int m_pos = 0;
    bit m_seen = 0;
    bit exp_tick = 0;
    bit exp_es = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_seen = 0; exp_tick = 0; exp_es = 0;
        end else begin
            bit h;
            h = |(defect & defect_en);
            exp_tick = (m_pos == T - 1);
            exp_es = exp_tick && m_seen;
            if (m_pos == T - 1) begin
                m_seen = h; m_pos = 0;
            end else begin
                m_seen = m_seen | h; m_pos++;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the reference.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R2 tick vs model", tick, exp_tick);
            check("R4 errored second vs model", es, exp_es);
            check("R3 es only with tick", es & ~tick, 1'b0);
        end
    end

    // One full window, entered on the negedge at window position 0.
    task automatic run_interval(input logic [7:0] d, input logic [7:0] en, input int pos,
                                input bit level, input logic exp, input string req);
        for (int i = 0; i < T; i++) begin
            defect = (level || i == pos) ? d : 8'h00;
            defect_en = en;
            @(negedge clk);
            if (i < T - 1) check("R2 no early tick", tick, 1'b0);
        end
        defect = '0;
        check({req, " tick at close"}, tick, 1'b1);
        check(req, es, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tick low in reset", tick, 1'b0);
        check("R1 es low in reset", es, 1'b0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        run_interval(8'h00, 8'hFF, 0, 0, 1'b0, "R2 quiet first window");

        for (int k = 0; k < 8; k++)
            run_interval(8'(1 << k), 8'(1 << k), 5, 0, 1'b1, $sformatf("R9 bit %0d flags window", k));

        for (int k = 0; k < 8; k++)
            run_interval(8'(1 << k), ~8'(1 << k), 0, 1, 1'b0, $sformatf("R5 masked bit %0d ignored", k));

        run_interval(8'hFF, 8'hFF, T - 1, 0, 1'b0, "R7 terminal-cycle defect not in closing window");
        run_interval(8'h00, 8'hFF, 0, 0, 1'b1, "R7 terminal-cycle defect in next window");

        run_interval(8'h01, 8'hFF, 0, 0, 1'b1, "R8 first-cycle defect flags");
        run_interval(8'h00, 8'hFF, 0, 0, 1'b0, "R8 record cleared next window");

        run_interval(8'h10, 8'hFF, 0, 1, 1'b1, "R6 held level window 1");
        run_interval(8'h10, 8'hFF, 0, 1, 1'b1, "R6 held level window 2");
        run_interval(8'h00, 8'hFF, 0, 0, 1'b1, "R7 level at terminal cycle carries");
        run_interval(8'h00, 8'hFF, 0, 0, 1'b0, "R8 quiet after level");

        // Random mix, compared by the reference every clock.
        for (int c = 0; c < 12 * T; c++) begin
            defect = ($urandom % 10 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            defect_en = 8'($urandom);
            @(negedge clk);
        end

        // Reset mid-window with a pending record.
        defect = 8'hFF; defect_en = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; defect = '0;
        @(negedge clk);
        check("R1 tick low after mid reset", tick, 1'b0);
        check("R1 es low after mid reset", es, 1'b0);
        rst_n = 1'b1;
        run_interval(8'h00, 8'hFF, 0, 0, 1'b0, "R1 record cleared by reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule